// File: doc/BRIEF.md
# Trap-Return State Restore Unit

This unit carries out the two ways of leaving a trap handler. "Done" resumes after the trapped instruction and "retry" re-executes it. On either strobe it looks up the saved trap-state entry for the current trap level. That entry is a saved program counter, a saved next program counter and one packed 64-bit state word. From it the unit reloads, in a single clock edge, the program counter pair, the condition codes, the address-space identifier, the processor-state word and the register-window pointer. It then lowers the trap level by one.

The unit also owns the eight active global registers and four backing banks: normal, alternate, MMU and interrupt. Three processor-state bits choose the bank. When the restored word selects a different bank than the current one, the active set is saved into the old bank and refilled from the new bank in the same cycle. A simple write port lets the surrounding pipeline update the active globals. Trap level starts at MAXTL after reset, so MAXTL returns are possible before the unit refuses further ones.

Top module: `trap_return_unit`

## Requirements
- R1: After reset, PC, NPC, condition codes, ASI, processor state, window pointer, all active globals and all bank contents are zero, the illegal flag is 0, and the trap level equals MAXTL.
- R2: The trap-state read index is the trap level minus one whenever the trap level is nonzero. The saved entry is read combinationally at that index.
- R3: An accepted done loads PC with the saved TNPC and NPC with the saved TNPC plus 4, visible after the next rising clock edge.
- R4: An accepted retry loads PC with the saved TPC and NPC with the saved TNPC, visible after the next rising clock edge.
- R5: An accepted return loads the 8-bit condition codes from state bits 39:32 and the ASI from state bits 31:24.
- R6: An accepted return loads the processor state from state bits 19:8 ANDed with 0xF3F. When GL_FEATURE is 1, bit 0 is also cleared. The window pointer is loaded from state bits 7:0 modulo NWINDOWS.
- R7: Each accepted return lowers the trap level by exactly one.
- R8: A done or retry strobe at trap level 0 changes no state and raises the illegal flag for exactly one cycle.
- R9: When done and retry are strobed together, the done behaviour applies.
- R10: Processor-state bits {11,10,0} select the global bank: 000 normal, 001 alternate, 010 MMU, 100 interrupt, and any other value normal. On an accepted return whose selected bank differs from the current one, the active globals are stored into the current bank and replaced by the new bank's contents.
- R11: When the selected bank does not change, or no return is accepted, the active globals change only through the write port.
- R12: With gWrEn high, entry gWrIdx of the active globals takes gWrData after the next edge. A write in a cycle that accepts a return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| doneStb | input | 1 | Done request |
| retryStb | input | 1 | Retry request |
| tsIdx | output | IDX_W | Trap-state entry index being read |
| tsTpc | input | ADDR_W | Saved PC of the indexed entry |
| tsTnpc | input | ADDR_W | Saved NPC of the indexed entry |
| tsTstate | input | 64 | Packed saved-state word of the indexed entry |
| gWrEn | input | 1 | Active-global write enable |
| gWrIdx | input | 3 | Active-global write index |
| gWrData | input | DATA_W | Active-global write data |
| pcOut | output | ADDR_W | Program counter |
| npcOut | output | ADDR_W | Next program counter |
| ccrOut | output | 8 | Condition codes (extended high nibble, integer low nibble) |
| asiOut | output | 8 | Address-space identifier |
| pstateOut | output | 12 | Processor-state word |
| cwpOut | output | CWP_W | Window pointer |
| tlOut | output | TL_W | Trap level |
| illegalOut | output | 1 | One-cycle illegal-return flag |
| globalsOut | output | 8*DATA_W | Active globals, entry g at bits g*DATA_W upward |

## Verification
The assertions assume the trap-state entry at tsIdx is stable and defined during the cycle a strobe is high. They also assume the restore only needs to be correct from the edge that samples the strobe. The bench meets this by holding a model storage array that is driven combinationally from tsIdx and rewritten only while no strobe is active. It draws random state words whose bank-select bits cover every legal bank and two unsupported combinations. It also makes random choices of done, retry, both together, and writes that collide with a return. Each round ends with strobes at trap level zero.

// File: rtl/trap_return_pkg.sv
package trap_return_pkg;

  localparam int GLOBALS   = 8;
  localparam int NUM_BANKS = 4;
  localparam int TSTATE_W  = 64;
  localparam logic [11:0] PSTATE_MASK = 12'hF3F;

  typedef enum logic [1:0] {
    BANK_NORMAL = 2'd0,
    BANK_ALT    = 2'd1,
    BANK_MMU    = 2'd2,
    BANK_INTR   = 2'd3
  } bank_e;

  typedef struct packed {
    logic accept;
    logic takeDone;
  } ctrlStrobes_t;

  function automatic bank_e bankOf(input logic [11:0] ps);
    case ({ps[11], ps[10], ps[0]})
      3'b001:  return BANK_ALT;
      3'b010:  return BANK_MMU;
      3'b100:  return BANK_INTR;
      default: return BANK_NORMAL;
    endcase
  endfunction

endpackage

// File: rtl/trap_return_ctrl.sv
module trap_return_ctrl
  import trap_return_pkg::*;
#(
  parameter int MAXTL = 6,
  parameter int TL_W  = $clog2(MAXTL + 1),
  parameter int IDX_W = (MAXTL > 1) ? $clog2(MAXTL) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             doneStb,
  input  logic             retryStb,
  output ctrlStrobes_t     strobes,
  output logic [TL_W-1:0]  tl,
  output logic [IDX_W-1:0] tsIdx,
  output logic             illegal
);

  logic anyStb;
  logic atZero;

  assign anyStb = doneStb | retryStb;
  assign atZero = (tl == '0);

  assign strobes.accept   = anyStb & ~atZero;
  assign strobes.takeDone = doneStb;

  assign tsIdx = atZero ? '0 : IDX_W'(tl - TL_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tl      <= TL_W'(MAXTL);
      illegal <= 1'b0;
    end else begin
      illegal <= anyStb & atZero;
      if (strobes.accept) tl <= tl - TL_W'(1);
    end
  end

  assert_tl_dec_R7: assert property (@(posedge clk) disable iff (!rstN)
    (anyStb && tl != '0) |=> (tl == $past(tl) - TL_W'(1)));

  assert_tl_zero_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (anyStb && tl == '0) |=> (illegal && tl == '0));

  assert_tl_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    tl <= TL_W'(MAXTL));

  assert_illegal_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!anyStb) |=> !illegal);

endmodule

// File: rtl/trap_return_dp.sv
module trap_return_dp
  import trap_return_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int DATA_W     = 64,
  parameter int NWINDOWS   = 6,
  parameter bit GL_FEATURE = 1'b0,
  parameter int CWP_W      = $clog2(NWINDOWS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobes_t             strobes,
  input  logic [ADDR_W-1:0]        tsTpc,
  input  logic [ADDR_W-1:0]        tsTnpc,
  input  logic [TSTATE_W-1:0]      tsTstate,
  input  logic                     gWrEn,
  input  logic [2:0]               gWrIdx,
  input  logic [DATA_W-1:0]        gWrData,
  output logic [ADDR_W-1:0]        pcOut,
  output logic [ADDR_W-1:0]        npcOut,
  output logic [7:0]               ccrOut,
  output logic [7:0]               asiOut,
  output logic [11:0]              pstateOut,
  output logic [CWP_W-1:0]         cwpOut,
  output logic [GLOBALS*DATA_W-1:0] globalsOut
);

  logic [DATA_W-1:0] active  [GLOBALS];
  logic [DATA_W-1:0] bankMem [NUM_BANKS][GLOBALS];

  logic [11:0]      newPs;
  logic [CWP_W-1:0] newCwp;
  bank_e            oldSel;
  bank_e            newSel;
  logic             swap;
  logic             unusedBits;

  assign unusedBits = ^{tsTstate[63:40], tsTstate[23:20]};

  always_comb begin
    newPs = tsTstate[19:8] & PSTATE_MASK;
    if (GL_FEATURE) newPs[0] = 1'b0;
  end

  assign newCwp = CWP_W'(32'(tsTstate[7:0]) % NWINDOWS);
  assign oldSel = bankOf(pstateOut);
  assign newSel = bankOf(newPs);
  assign swap   = strobes.accept && (oldSel != newSel);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcOut     <= '0;
      npcOut    <= '0;
      ccrOut    <= '0;
      asiOut    <= '0;
      pstateOut <= '0;
      cwpOut    <= '0;
    end else if (strobes.accept) begin
      pcOut     <= strobes.takeDone ? tsTnpc : tsTpc;
      npcOut    <= strobes.takeDone ? tsTnpc + ADDR_W'(4) : tsTnpc;
      ccrOut    <= tsTstate[39:32];
      asiOut    <= tsTstate[31:24];
      pstateOut <= newPs;
      cwpOut    <= newCwp;
    end
  end

  always_ff @(posedge clk) begin
    for (int g = 0; g < GLOBALS; g++) begin
      if (!rstN) begin
        active[g] <= '0;
      end else if (swap) begin
        active[g] <= bankMem[newSel][g];
      end else if (!strobes.accept && gWrEn && gWrIdx == 3'(g)) begin
        active[g] <= gWrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int g = 0; g < GLOBALS; g++) begin
        if (!rstN) begin
          bankMem[b][g] <= '0;
        end else if (swap && oldSel == bank_e'(b)) begin
          bankMem[b][g] <= active[g];
        end
      end
    end
  end

  for (genvar g = 0; g < GLOBALS; g++) begin : gFlat
    assign globalsOut[g*DATA_W +: DATA_W] = active[g];
  end

  assert_cwp_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    cwpOut < CWP_W'(NWINDOWS));

  assert_pstate_mask_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pstateOut & ~PSTATE_MASK) == 12'h000);

  assert_done_npc_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.accept && strobes.takeDone) |=> (npcOut == pcOut + ADDR_W'(4)));

  assert_globals_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.accept && !gWrEn) |=> $stable(globalsOut));

  assert_regs_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.accept) |=> ($stable(pcOut) && $stable(pstateOut) && $stable(cwpOut)));

endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
  import trap_return_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int DATA_W     = 64,
  parameter int NWINDOWS   = 6,
  parameter int MAXTL      = 6,
  parameter bit GL_FEATURE = 1'b0,
  parameter int CWP_W      = $clog2(NWINDOWS),
  parameter int TL_W       = $clog2(MAXTL + 1),
  parameter int IDX_W      = (MAXTL > 1) ? $clog2(MAXTL) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      doneStb,
  input  logic                      retryStb,
  output logic [IDX_W-1:0]          tsIdx,
  input  logic [ADDR_W-1:0]         tsTpc,
  input  logic [ADDR_W-1:0]         tsTnpc,
  input  logic [63:0]               tsTstate,
  input  logic                      gWrEn,
  input  logic [2:0]                gWrIdx,
  input  logic [DATA_W-1:0]         gWrData,
  output logic [ADDR_W-1:0]         pcOut,
  output logic [ADDR_W-1:0]         npcOut,
  output logic [7:0]                ccrOut,
  output logic [7:0]                asiOut,
  output logic [11:0]               pstateOut,
  output logic [CWP_W-1:0]          cwpOut,
  output logic [TL_W-1:0]           tlOut,
  output logic                      illegalOut,
  output logic [8*DATA_W-1:0]       globalsOut
);

  ctrlStrobes_t strobes;

  trap_return_ctrl #(
    .MAXTL (MAXTL),
    .TL_W  (TL_W),
    .IDX_W (IDX_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .doneStb  (doneStb),
    .retryStb (retryStb),
    .strobes  (strobes),
    .tl       (tlOut),
    .tsIdx    (tsIdx),
    .illegal  (illegalOut)
  );

  trap_return_dp #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .NWINDOWS   (NWINDOWS),
    .GL_FEATURE (GL_FEATURE),
    .CWP_W      (CWP_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .tsTpc      (tsTpc),
    .tsTnpc     (tsTnpc),
    .tsTstate   (tsTstate),
    .gWrEn      (gWrEn),
    .gWrIdx     (gWrIdx),
    .gWrData    (gWrData),
    .pcOut      (pcOut),
    .npcOut     (npcOut),
    .ccrOut     (ccrOut),
    .asiOut     (asiOut),
    .pstateOut  (pstateOut),
    .cwpOut     (cwpOut),
    .globalsOut (globalsOut)
  );

endmodule

// File: tb/trap_return_unit_bench.sv
`timescale 1ns/1ps
module trap_return_unit_bench;

  localparam int AW = 64;
  localparam int DW = 64;
  localparam int NW = 6;
  localparam int MT = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          doneStb = 1'b0;
  logic          retryStb = 1'b0;
  logic [2:0]    tsIdx;
  logic [AW-1:0] tsTpc, tsTnpc;
  logic [63:0]   tsTstate;
  logic          gWrEn = 1'b0;
  logic [2:0]    gWrIdx = '0;
  logic [DW-1:0] gWrData = '0;
  logic [AW-1:0] pcOut, npcOut;
  logic [7:0]    ccrOut, asiOut;
  logic [11:0]   pstateOut;
  logic [2:0]    cwpOut;
  logic [2:0]    tlOut;
  logic          illegalOut;
  logic [8*DW-1:0] globalsOut;

  logic [AW-1:0] memTpc [8];
  logic [AW-1:0] memTnpc[8];
  logic [63:0]   memTs  [8];

  assign tsTpc    = memTpc[tsIdx];
  assign tsTnpc   = memTnpc[tsIdx];
  assign tsTstate = memTs[tsIdx];

  trap_return_unit u_trap_return_unit (
    .clk(clk), .rstN(rstN), .doneStb(doneStb), .retryStb(retryStb),
    .tsIdx(tsIdx), .tsTpc(tsTpc), .tsTnpc(tsTnpc), .tsTstate(tsTstate),
    .gWrEn(gWrEn), .gWrIdx(gWrIdx), .gWrData(gWrData),
    .pcOut(pcOut), .npcOut(npcOut), .ccrOut(ccrOut), .asiOut(asiOut),
    .pstateOut(pstateOut), .cwpOut(cwpOut), .tlOut(tlOut),
    .illegalOut(illegalOut), .globalsOut(globalsOut)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [AW-1:0] ePc, eNpc;
  logic [7:0]    eCcr, eAsi;
  logic [11:0]   ePs;
  logic [2:0]    eCwp;
  int            eTl;
  logic          eIll;
  logic [DW-1:0] eAct [8];
  logic [DW-1:0] eBank[4][8];

  function automatic int selOf(input logic [11:0] ps);
    case ({ps[11], ps[10], ps[0]})
      3'b001:  return 1;
      3'b010:  return 2;
      3'b100:  return 3;
      default: return 0;
    endcase
  endfunction

  function automatic logic [63:0] makeTs();
    logic [2:0] sel;
    logic [11:0] ps;
    case ($urandom % 6)
      0: sel = 3'b000;
      1: sel = 3'b001;
      2: sel = 3'b010;
      3: sel = 3'b100;
      4: sel = 3'b011;
      default: sel = 3'b110;
    endcase
    ps = 12'($urandom);
    ps[11] = sel[2]; ps[10] = sel[1]; ps[0] = sel[0];
    return {24'($urandom), 8'($urandom), 8'($urandom), 4'($urandom), ps, 8'($urandom)};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    check(req, "pc", pcOut, ePc);
    check(req, "npc", npcOut, eNpc);
    check(req, "ccr R5", 64'(ccrOut), 64'(eCcr));
    check(req, "asi R5", 64'(asiOut), 64'(eAsi));
    check(req, "pstate R6", 64'(pstateOut), 64'(ePs));
    check(req, "cwp R6", 64'(cwpOut), 64'(eCwp));
    check(req, "tl R7", 64'(tlOut), 64'(eTl));
    check(req, "illegal R8", 64'(illegalOut), 64'(eIll));
    if (eTl > 0) check(req, "index R2", 64'(tsIdx), 64'(eTl - 1));
    for (int g = 0; g < 8; g++)
      check(req, "global R10", globalsOut[g*DW +: DW], eAct[g]);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    ePc = '0; eNpc = '0; eCcr = '0; eAsi = '0; ePs = '0; eCwp = '0;
    eTl = MT; eIll = 1'b0;
    for (int g = 0; g < 8; g++) begin
      eAct[g] = '0;
      for (int b = 0; b < 4; b++) eBank[b][g] = '0;
    end
  endtask

  task automatic writeGlobal(input int idx, input logic [DW-1:0] val);
    gWrEn = 1'b1; gWrIdx = 3'(idx); gWrData = val;
    @(negedge clk);
    gWrEn = 1'b0;
    eAct[idx] = val;
    eIll = 1'b0;
  endtask

  task automatic doReturn(input bit dn, input bit rt, input bit wr, input string req);
    int idx;
    logic [63:0] ts;
    logic [11:0] nps;
    int os, ns;
    idx = eTl - 1;
    doneStb = dn; retryStb = rt;
    gWrEn = wr; gWrIdx = 3'($urandom); gWrData = {$urandom, $urandom};
    @(negedge clk);
    doneStb = 1'b0; retryStb = 1'b0; gWrEn = 1'b0;
    if (eTl == 0) begin
      eIll = 1'b1;
      if (wr) eAct[gWrIdx] = gWrData;
    end else begin
      eIll = 1'b0;
      ts = memTs[idx];
      if (dn) begin
        ePc = memTnpc[idx]; eNpc = memTnpc[idx] + 64'd4;
      end else begin
        ePc = memTpc[idx]; eNpc = memTnpc[idx];
      end
      eCcr = ts[39:32]; eAsi = ts[31:24];
      nps = ts[19:8] & 12'hF3F;
      eCwp = 3'(int'(ts[7:0]) % NW);
      os = selOf(ePs); ns = selOf(nps);
      if (os != ns) begin
        for (int g = 0; g < 8; g++) eBank[os][g] = eAct[g];
        for (int g = 0; g < 8; g++) eAct[g] = eBank[ns][g];
      end
      ePs = nps;
      eTl = eTl - 1;
    end
    checkAll(req);
  endtask

  task automatic fillMem(input bit directed);
    for (int i = 0; i < 8; i++) begin
      memTpc[i]  = {$urandom, $urandom};
      memTnpc[i] = {$urandom, $urandom};
      memTs[i]   = makeTs();
    end
    if (directed) begin
      memTs[5] = {24'h0, 8'hA5, 8'h3C, 4'h0, 12'h001, 8'd13};
      memTs[4] = {24'h0, 8'h5A, 8'hC3, 4'h0, 12'h400, 8'd255};
      memTs[3] = {24'h0, 8'h11, 8'h22, 4'h0, 12'h4C0, 8'd5};
      memTs[2] = {24'h0, 8'h33, 8'h44, 4'h0, 12'h801, 8'd6};
      memTs[1] = {24'h0, 8'h00, 8'hFF, 4'h0, 12'h800, 8'd0};
      memTs[0] = {24'h0, 8'hFF, 8'h00, 4'h0, 12'hFFF, 8'd7};
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      memTpc[i] = '0; memTnpc[i] = '0; memTs[i] = '0;
    end
    void'($urandom(32'd1234));
    doReset();
    @(negedge clk);
    checkAll("R1");

    fillMem(1'b1);
    for (int g = 0; g < 8; g++) writeGlobal(g, 64'h1000 + 64'(g));
    checkAll("R12");
    doReturn(1'b1, 1'b0, 1'b0, "R3");
    doReturn(1'b0, 1'b1, 1'b0, "R4");
    for (int g = 0; g < 8; g++) writeGlobal(g, 64'h2000 + 64'(g));
    doReturn(1'b1, 1'b1, 1'b0, "R9");
    doReturn(1'b0, 1'b1, 1'b1, "R12");
    doReturn(1'b1, 1'b0, 1'b0, "R10");
    doReturn(1'b0, 1'b1, 1'b0, "R11");
    doReturn(1'b1, 1'b0, 1'b0, "R8");
    @(negedge clk);
    eIll = 1'b0;
    checkAll("R8");
    doReturn(1'b0, 1'b1, 1'b1, "R8");

    for (int r = 0; r < 25; r++) begin
      doReset();
      @(negedge clk);
      checkAll("R1");
      fillMem(1'b0);
      for (int g = 0; g < 8; g++) writeGlobal(g, {$urandom, $urandom});
      for (int k = 0; k < MT + 1; k++) begin
        int op;
        op = $urandom % 3;
        doReturn(op != 1, op != 0, 1'($urandom), "R10");
        if ($urandom % 2 == 1) begin
          writeGlobal(int'($urandom % 8), {$urandom, $urandom});
          checkAll("R12");
        end
      end
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule